// File: doc/BRIEF.md
# Residue-Coded Selector Function Generator

This block evaluates an arbitrary Boolean function of `NUM_VARS` inputs using one selector with `NUM_VARS-1` select bits. The upper variables drive the select lines. The lowest variable (called z here) is held back. Each data line of the selector carries a two-bit residue code, and that code turns z into the line's value: a constant 0, a constant 1, z itself, or its complement. Because z is available in both polarities, a selector with half as many lines as the truth table has rows covers every function.

Configuration is held in a small register file loaded through a write port. A write either stores one residue code into one line, or takes a full minterm mask (the truth table) and derives every line's code from it in a single cycle. A mask load also latches the select-order setting, so the two upper select variables can be presented in either order. The output is purely combinational from the variable inputs and the stored codes, and is forced low when the enable is low.

Top module: `residue_fgen`

## Requirements
- R1: While reset is asserted and after its release, every line code is 2'b00 and the order setting is straight, so `fOut` is 0 for every input combination.
- R2: When `enable` is 0, `fOut` is 0 whatever the inputs and the stored codes.
- R3: With `enable` at 1, the selected line's code sets the output: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives z (`varIn[0]`), 2'b11 gives the complement of z.
- R4: With the straight order, the line index is `varIn[NUM_VARS-1:1]` taken as an unsigned number, so for three variables x=`varIn[2]` drives select bit 1 and y=`varIn[1]` drives select bit 0.
- R5: A clock edge with `cfgWrEn`=1 and `cfgWrMask`=0 stores `cfgCode` into line `cfgLine`; every other line and the order setting keep their values; the new code drives `fOut` from the next cycle.
- R6: A clock edge with `cfgWrEn`=1 and `cfgWrMask`=1 reloads all lines from `cfgMask`, where bit index `varIn` (z as bit 0) holds the function value; from the next cycle `fOut` equals `enable & cfgMask[varIn]` for every input.
- R7: The code derived for a line from its pair (value at z=0, value at z=1) is 2'b00 for (0,0), 2'b01 for (1,1), 2'b10 for (0,1) and 2'b11 for (1,0).
- R8: A mask load latches `cfgSwap`; when it is 1 the select bits are taken from `varIn[NUM_VARS-1:1]` in reversed bit order, later single-line writes address lines in that reversed order, and a mask load still yields `fOut = enable & cfgMask[varIn]`.
- R9: With `cfgWrEn` at 0, changes on `cfgLine`, `cfgCode`, `cfgMask` and `cfgSwap` alter no stored state.
- R10: The same behaviour holds for `NUM_VARS`=4, using an 8-line selector and a 16-bit mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrMask | input | 1 | 1 selects a mask load, 0 a single-line write |
| cfgLine | input | NUM_VARS-1 | Line index for a single-line write |
| cfgCode | input | 2 | Residue code for a single-line write |
| cfgMask | input | 2**NUM_VARS | Truth table for a mask load |
| cfgSwap | input | 1 | Select-order setting latched on a mask load |
| varIn | input | NUM_VARS | Function variables, z in bit 0 |
| enable | input | 1 | Active-high output enable |
| fOut | output | 1 | Function value |

## Verification
The embedded assertions watch, on every cycle, that a low enable forces the output low, that a single-line write lands in exactly the addressed line, that no configuration state moves without a write strobe, that the order setting only changes on a mask load, and that the two write strobes never fire together. What they cannot show is that the derived residue codes reproduce the intended function; only the bench scenarios can do that, by sweeping every three-variable truth table in both select orders and a set of four-variable tables, comparing each output against a direct lookup into the mask, and by checking the code-to-value map, reversed-order addressing and ignored writes through the output.

// File: rtl/residue_fgen_pkg.sv
package residue_fgen_pkg;

  typedef enum logic [1:0] {
    RES_ZERO = 2'b00,
    RES_ONE  = 2'b01,
    RES_TRUE = 2'b10,
    RES_INV  = 2'b11
  } residue_e;

  typedef struct packed {
    logic loadOne;
    logic loadAll;
  } cfgStrobe_t;

  // Code for a line from its two truth-table cells (z=0 value, z=1 value).
  function automatic residue_e residueOf(input logic atZ0, input logic atZ1);
    case ({atZ0, atZ1})
      2'b00:   return RES_ZERO;
      2'b11:   return RES_ONE;
      2'b01:   return RES_TRUE;
      default: return RES_INV;
    endcase
  endfunction

  function automatic logic applyResidue(input logic [1:0] code, input logic zVal);
    case (code)
      RES_ZERO: return 1'b0;
      RES_ONE:  return 1'b1;
      RES_TRUE: return zVal;
      default:  return ~zVal;
    endcase
  endfunction

endpackage

// File: rtl/residue_fgen_ctrl.sv
module residue_fgen_ctrl
  import residue_fgen_pkg::*;
#(
  parameter int NUM_VARS = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic                      cfgWrMask,
  input  logic                      cfgSwap,
  input  logic [(2**NUM_VARS)-1:0]  cfgMask,
  output cfgStrobe_t                strobe,
  output logic [(2**(NUM_VARS-1))-1:0][1:0] derivedCodes
);
  localparam int SEL_W = NUM_VARS - 1;
  localparam int LINES = 2 ** SEL_W;

  always_comb begin
    strobe.loadOne = cfgWrEn & ~cfgWrMask;
    strobe.loadAll = cfgWrEn & cfgWrMask;
  end

  // For each line, find which pair of truth-table cells it covers.
  for (genvar L = 0; L < LINES; L++) begin : g_line
    localparam logic [SEL_W-1:0] LINE_IDX = L[SEL_W-1:0];
    logic [SEL_W-1:0] revIdx;
    logic [SEL_W-1:0] cellIdx;
    for (genvar b = 0; b < SEL_W; b++) begin : g_rev
      assign revIdx[b] = LINE_IDX[SEL_W-1-b];
    end
    assign cellIdx = cfgSwap ? revIdx : LINE_IDX;
    always_comb begin
      derivedCodes[L] = residueOf(cfgMask[{cellIdx, 1'b0}], cfgMask[{cellIdx, 1'b1}]);
    end
  end

  // R5/R6: a write is either a single line or a full reload, never both.
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadOne, strobe.loadAll}));

endmodule

// File: rtl/residue_fgen_dp.sv
module residue_fgen_dp
  import residue_fgen_pkg::*;
#(
  parameter int NUM_VARS = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cfgStrobe_t                strobe,
  input  logic [NUM_VARS-2:0]       wrLine,
  input  logic [1:0]                wrCode,
  input  logic                      wrSwap,
  input  logic [(2**(NUM_VARS-1))-1:0][1:0] derivedCodes,
  input  logic [NUM_VARS-1:0]       varIn,
  input  logic                      enable,
  output logic                      fOut
);
  localparam int SEL_W = NUM_VARS - 1;
  localparam int LINES = 2 ** SEL_W;

  logic [LINES-1:0][1:0] codeReg;
  logic                  swapReg;
  logic [SEL_W-1:0]      upperVars;
  logic [SEL_W-1:0]      revVars;
  logic [SEL_W-1:0]      selIdx;
  logic [1:0]            selCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg <= '0;
      swapReg <= 1'b0;
    end else if (strobe.loadAll) begin
      codeReg <= derivedCodes;
      swapReg <= wrSwap;
    end else if (strobe.loadOne) begin
      codeReg[wrLine] <= wrCode;
    end
  end

  assign upperVars = varIn[NUM_VARS-1:1];
  for (genvar b = 0; b < SEL_W; b++) begin : g_rev
    assign revVars[b] = upperVars[SEL_W-1-b];
  end

  always_comb begin
    selIdx  = swapReg ? revVars : upperVars;
    selCode = codeReg[selIdx];
    fOut    = enable & applyResidue(selCode, varIn[0]);
  end

  a_r2_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !fOut);

  a_r5_line_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOne |=> codeReg[$past(wrLine)] == $past(wrCode));

  a_r9_hold_codes: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadOne || strobe.loadAll) |=> $stable(codeReg));

  a_r8_swap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadAll |=> $stable(swapReg));

endmodule

// File: rtl/residue_fgen.sv
module residue_fgen
  import residue_fgen_pkg::*;
#(
  parameter int NUM_VARS = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWrEn,
  input  logic                       cfgWrMask,
  input  logic [NUM_VARS-2:0]        cfgLine,
  input  logic [1:0]                 cfgCode,
  input  logic [(2**NUM_VARS)-1:0]   cfgMask,
  input  logic                       cfgSwap,
  input  logic [NUM_VARS-1:0]        varIn,
  input  logic                       enable,
  output logic                       fOut
);
  localparam int LINES = 2 ** (NUM_VARS - 1);

  cfgStrobe_t            strobe;
  logic [LINES-1:0][1:0] derivedCodes;

  residue_fgen_ctrl #(.NUM_VARS(NUM_VARS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgWrMask    (cfgWrMask),
    .cfgSwap      (cfgSwap),
    .cfgMask      (cfgMask),
    .strobe       (strobe),
    .derivedCodes (derivedCodes)
  );

  residue_fgen_dp #(.NUM_VARS(NUM_VARS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrLine       (cfgLine),
    .wrCode       (cfgCode),
    .wrSwap       (cfgSwap),
    .derivedCodes (derivedCodes),
    .varIn        (varIn),
    .enable       (enable),
    .fOut         (fOut)
  );

endmodule

// File: tb/tb_residue_fgen.sv
`timescale 1ns/1ps
module tb_residue_fgen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0, cfgWrMask = 1'b0, cfgSwap = 1'b0, enable = 1'b0;
  logic [1:0] cfgLine = '0;
  logic [1:0] cfgCode = '0;
  logic [7:0] cfgMask = '0;
  logic [2:0] varIn = '0;
  logic       fOut;

  logic        c4WrEn = 1'b0, c4Swap = 1'b0;
  logic [15:0] c4Mask = '0;
  logic [3:0]  c4Var = '0;
  logic        c4Out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  residue_fgen #(.NUM_VARS(3)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrMask(cfgWrMask),
    .cfgLine(cfgLine), .cfgCode(cfgCode), .cfgMask(cfgMask), .cfgSwap(cfgSwap),
    .varIn(varIn), .enable(enable), .fOut(fOut));

  residue_fgen #(.NUM_VARS(4)) dut4 (
    .clk(clk), .rstN(rstN), .cfgWrEn(c4WrEn), .cfgWrMask(1'b1),
    .cfgLine(3'd0), .cfgCode(2'b00), .cfgMask(c4Mask), .cfgSwap(c4Swap),
    .varIn(c4Var), .enable(1'b1), .fOut(c4Out));

  // {swap, 16-bit mask} for the four-variable instance (R10).
  localparam logic [16:0] VEC4 [8] = '{
    17'h0_0000, 17'h0_FFFF, 17'h0_6996, 17'h1_6996,
    17'h0_8001, 17'h1_1234, 17'h0_F0C3, 17'h1_A55A
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (varIn=%b)", req, act, exp, varIn);
    end
  endtask

  task automatic loadMask(input logic [7:0] m, input logic sw);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrMask = 1'b1; cfgMask = m; cfgSwap = sw;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgMask = ~m; cfgSwap = ~sw;
  endtask

  task automatic writeLine(input logic [1:0] line, input logic [1:0] code);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrMask = 1'b0; cfgLine = line; cfgCode = code;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  function automatic logic codeVal(input logic [1:0] c, input logic z);
    case (c)
      2'b00: return 1'b0;
      2'b01: return 1'b1;
      2'b10: return z;
      default: return ~z;
    endcase
  endfunction

  task automatic sweepMask(input logic [7:0] m, input string req);
    for (int v = 0; v < 8; v++) begin
      varIn = v[2:0];
      #0.5;
      check(req, fOut, enable & m[v]);
    end
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [1:0] codes [4];
    enable = 1'b1;
    // R1: output low during reset
    for (int v = 0; v < 8; v++) begin
      varIn = v[2:0]; #0.5; check("R1", fOut, 1'b0);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    sweepMask(8'h00, "R1");

    // R10: table of four-variable vectors walked by one loop
    foreach (VEC4[i]) begin
      @(negedge clk);
      c4WrEn = 1'b1; c4Mask = VEC4[i][15:0]; c4Swap = VEC4[i][16];
      @(negedge clk);
      c4WrEn = 1'b0; c4Mask = '0;
      for (int v = 0; v < 16; v++) begin
        c4Var = v[3:0]; #0.5;
        checks++;
        if (c4Out !== VEC4[i][v]) begin
          fails++;
          $display("FAIL R10: actual %b expected %b (vec %0d var %0d)", c4Out, VEC4[i][v], i, v);
        end
      end
    end

    // R6 / R7 / R8: every three-variable function in both select orders
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 256; m++) begin
        loadMask(m[7:0], s[0]);
        sweepMask(m[7:0], s == 0 ? "R6_R7" : "R8");
      end
    end

    // R3 / R4 / R5: direct line writes, straight order
    loadMask(8'h00, 1'b0);
    codes[0] = 2'b00; codes[1] = 2'b01; codes[2] = 2'b10; codes[3] = 2'b11;
    for (int L = 0; L < 4; L++) writeLine(L[1:0], codes[L]);
    for (int v = 0; v < 8; v++) begin
      varIn = v[2:0]; #0.5;
      check("R3_R4", fOut, codeVal(codes[v >> 1], v[0]));
    end
    // R5: rewrite one line, others unchanged
    writeLine(2'd2, 2'b01);
    codes[2] = 2'b01;
    for (int v = 0; v < 8; v++) begin
      varIn = v[2:0]; #0.5;
      check("R5", fOut, codeVal(codes[v >> 1], v[0]));
    end

    // R9: inputs wiggle with write strobe low
    @(negedge clk);
    cfgLine = 2'd0; cfgCode = 2'b01; cfgMask = 8'hFF; cfgSwap = 1'b1; cfgWrMask = 1'b1;
    repeat (3) @(negedge clk);
    cfgWrMask = 1'b0;
    repeat (2) @(negedge clk);
    for (int v = 0; v < 8; v++) begin
      varIn = v[2:0]; #0.5;
      check("R9", fOut, codeVal(codes[v >> 1], v[0]));
    end

    // R2: enable low masks an all-ones function
    loadMask(8'hFF, 1'b0);
    enable = 1'b0;
    sweepMask(8'hFF, "R2");
    enable = 1'b1;

    // R8: reversed order addressing for single-line writes
    loadMask(8'h00, 1'b1);
    writeLine(2'b01, 2'b01);   // S1=y=0, S0=x=1
    for (int v = 0; v < 8; v++) begin
      varIn = v[2:0]; #0.5;
      check("R8", fOut, (v[2] == 1'b1) && (v[1] == 1'b0));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule